// File: doc/BRIEF.md
# Dual Q31-to-Q15 Rounding Packer

This block narrows two signed fixed-point operands of full word width to half width and places both results in one output word. Each operand is rounded toward positive infinity: half of one result LSB is added, then the upper half of the sum is kept. An operand large enough that the rounding would carry past the largest positive half-width value saturates to that maximum. Negative operands cannot overflow, because rounding only moves values upward.

Every saturation event sets a sticky overflow flag held at a fixed bit of a word-wide DSP control register. The register has a plain write port and a continuous read port. Software clears the flag by writing the register. All other bits of the register are kept exactly as written, so the block can hold the surrounding control fields of a larger DSP unit without touching them. The packed result and its valid flag are registered and appear one clock after the operand strobe.

Top module: `dqp_packer`

## Requirements
- R1: For an operand not above the saturation threshold, its result half equals bits [31:16] of (operand + 0x00008000), computed modulo 2^32.
- R2: The result of the first operand (`op_hi_i`) is placed in bits [31:16] of `res_o`, and the result of the second operand (`op_lo_i`) in bits [15:0].
- R3: An operand that is greater than 0x7FFF7FFF as a signed value yields the result half 0x7FFF.
- R4: When either half of an accepted operation saturates, bit 22 of the control register reads 1 after that clock edge.
- R5: An operand with bit 31 set never saturates, and on its own it never sets the overflow flag.
- R6: The overflow flag is sticky: an operation without saturation leaves bit 22 unchanged, and only a control register write can clear it.
- R7: `res_o` and `res_valid_o` update on the clock edge that samples `op_valid_i` high. `res_valid_o` is high for exactly that one cycle, and `res_o` holds its value while no operation is accepted.
- R8: A control register write stores `ctl_wdata_i` and is read back on `ctl_rdata_o` after the edge. Bits other than bit 22 change only through such writes.
- R9: When a write and a saturating operation fall in the same cycle, bit 22 reads 1 regardless of the written value. All other bits take the written value.
- R10: After reset, `res_o`, `res_valid_o` and `ctl_rdata_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_valid_i | input | 1 | Operand strobe; the operands are accepted on this cycle |
| op_hi_i | input | 32 | First signed operand; its result goes to the upper half |
| op_lo_i | input | 32 | Second signed operand; its result goes to the lower half |
| res_valid_o | output | 1 | High for one cycle when `res_o` carries a new result |
| res_o | output | 32 | Packed rounded and saturated halves |
| ctl_we_i | input | 1 | Control register write enable |
| ctl_wdata_i | input | 32 | Control register write data |
| ctl_rdata_o | output | 32 | Control register contents; bit 22 is the sticky overflow flag |

## Verification
On every cycle the assertions check the following: saturated halves carry the maximum value, negative operands never produce it, the flag is set after any saturation and stays set until a write, untouched control bits stay stable, and results appear and hold with the expected latency. The exact rounded value of each half, the packing order, and the precedence of the flag set over a write in the same cycle are shown by the bench scenarios. These compare every result against an arithmetic model. The bench sweeps full-width boundary operands on the default instance and runs a near-exhaustive operand sweep on an 8-bit instance. That instance rounds at a 4-bit half, so the same arithmetic is exercised over almost all of its operand space.

// File: rtl/dqp_pkg.sv
package dqp_pkg;

  // Default geometry of the packer
  localparam int unsigned DQP_OP_W     = 32;
  localparam int unsigned DQP_CTRL_W   = 32;
  localparam int unsigned DQP_FLAG_POS = 22;
  localparam int unsigned DQP_LANES    = 2;

  // Largest positive value of a signed field of the given width
  function automatic longint dqp_max_pos(input int unsigned width);
    return (longint'(1) << (width - 1)) - 1;
  endfunction

endpackage

// File: rtl/dqp_rst_sync.sv
module dqp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;

endmodule

// File: rtl/dqp_round_lane.sv
// One lane: round toward +infinity to the upper half, saturate positive overflow.
module dqp_round_lane #(
  parameter int unsigned OP_W = dqp_pkg::DQP_OP_W
) (
  input  logic [OP_W-1:0]   op_i,
  output logic [OP_W/2-1:0] half_o,
  output logic              sat_o
);

  localparam int unsigned HALF_W = OP_W / 2;
  localparam logic [HALF_W-1:0] HALF_MAX = {1'b0, {(HALF_W-1){1'b1}}};

  logic [HALF_W-1:0] upper_sum;
  logic              round_carry;
  logic              lane_unused;

  // Adding half an output LSB only carries into the upper half when the
  // bit just below the split is set; the lower sum bits are discarded.
  assign round_carry = op_i[HALF_W-1];
  assign upper_sum   = op_i[OP_W-1:HALF_W] + HALF_W'(round_carry);

  // A non-negative operand whose rounded sum turns negative has overflowed.
  assign sat_o  = ~op_i[OP_W-1] & upper_sum[HALF_W-1];
  assign half_o = sat_o ? HALF_MAX : upper_sum;

  assign lane_unused = ^op_i[HALF_W-2:0];

endmodule

// File: rtl/dqp_ctrl_reg.sv
// Control word with a sticky overflow flag at a fixed bit.
module dqp_ctrl_reg #(
  parameter int unsigned CTRL_W   = dqp_pkg::DQP_CTRL_W,
  parameter int unsigned FLAG_POS = dqp_pkg::DQP_FLAG_POS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              flag_set_i,
  output logic [CTRL_W-1:0] rdata_o
);

  logic [CTRL_W-1:0] ctl_q;
  logic [CTRL_W-1:0] ctl_d;
  logic              ctl_en;

  assign ctl_en = we_i | flag_set_i;

  always_comb begin
    ctl_d = ctl_q;
    if (we_i) begin
      ctl_d = wdata_i;
    end
    if (flag_set_i) begin
      ctl_d[FLAG_POS] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  assign rdata_o = ctl_q;

endmodule

// File: rtl/dqp_packer.sv
module dqp_packer #(
  parameter int unsigned OP_W     = dqp_pkg::DQP_OP_W,
  parameter int unsigned CTRL_W   = dqp_pkg::DQP_CTRL_W,
  parameter int unsigned FLAG_POS = dqp_pkg::DQP_FLAG_POS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [OP_W-1:0]   op_hi_i,
  input  logic [OP_W-1:0]   op_lo_i,
  output logic              res_valid_o,
  output logic [OP_W-1:0]   res_o,
  input  logic              ctl_we_i,
  input  logic [CTRL_W-1:0] ctl_wdata_i,
  output logic [CTRL_W-1:0] ctl_rdata_o
);

  localparam int unsigned LANES  = dqp_pkg::DQP_LANES;
  localparam int unsigned HALF_W = OP_W / 2;
  localparam int unsigned RES_W  = LANES * HALF_W;

  logic                       rst_sync_n;
  logic [LANES-1:0][OP_W-1:0] lane_op;
  logic [LANES-1:0]           lane_sat;
  logic [RES_W-1:0]           res_d;
  logic [RES_W-1:0]           res_q;
  logic                       res_valid_q;
  logic                       flag_set;

  dqp_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  // Lane 0 fills the low half, the top lane the high half.
  assign lane_op[0]       = op_lo_i;
  assign lane_op[LANES-1] = op_hi_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dqp_round_lane #(
      .OP_W (OP_W)
    ) u_lane (
      .op_i   (lane_op[l]),
      .half_o (res_d[l*HALF_W +: HALF_W]),
      .sat_o  (lane_sat[l])
    );
  end

  assign flag_set = op_valid_i & (|lane_sat);

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
    end else if (op_valid_i) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid_q <= 1'b0;
    end else begin
      res_valid_q <= op_valid_i;
    end
  end

  dqp_ctrl_reg #(
    .CTRL_W   (CTRL_W),
    .FLAG_POS (FLAG_POS)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .we_i       (ctl_we_i),
    .wdata_i    (ctl_wdata_i),
    .flag_set_i (flag_set),
    .rdata_o    (ctl_rdata_o)
  );

  assign res_o       = res_q;
  assign res_valid_o = res_valid_q;

endmodule

// File: rtl/dqp_packer_chk.sv
module dqp_packer_chk #(
  parameter int unsigned OP_W     = 32,
  parameter int unsigned CTRL_W   = 32,
  parameter int unsigned FLAG_POS = 22
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              op_valid_i,
  input logic [OP_W-1:0]   op_hi_i,
  input logic [OP_W-1:0]   op_lo_i,
  input logic              res_valid_o,
  input logic [OP_W-1:0]   res_o,
  input logic              ctl_we_i,
  input logic [CTRL_W-1:0] ctl_wdata_i,
  input logic [CTRL_W-1:0] ctl_rdata_o
);

  localparam int unsigned HALF_W = OP_W / 2;
  localparam longint SAT_THR =
    dqp_pkg::dqp_max_pos(OP_W) - (longint'(1) << (HALF_W - 1));
  localparam logic [HALF_W-1:0] HALF_MAX = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [CTRL_W-1:0] FLAG_MASK = CTRL_W'(1) << FLAG_POS;

  logic hi_over;
  logic lo_over;
  logic any_over;

  assign hi_over  = longint'($signed(op_hi_i)) > SAT_THR;
  assign lo_over  = longint'($signed(op_lo_i)) > SAT_THR;
  assign any_over = op_valid_i & (hi_over | lo_over);

  AST_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_n)
    op_valid_i && hi_over |=> res_o[OP_W-1:HALF_W] == HALF_MAX); // R3
  AST_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_n)
    op_valid_i && lo_over |=> res_o[HALF_W-1:0] == HALF_MAX); // R3
  AST_NEG_HI: assert property (@(posedge clk_i) disable iff (!rst_n)
    op_valid_i && op_hi_i[OP_W-1] |=> res_o[OP_W-1:HALF_W] != HALF_MAX); // R5
  AST_NEG_LO: assert property (@(posedge clk_i) disable iff (!rst_n)
    op_valid_i && op_lo_i[OP_W-1] |=> res_o[HALF_W-1:0] != HALF_MAX); // R5
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_n)
    any_over |=> ctl_rdata_o[FLAG_POS]); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ctl_we_i && ctl_rdata_o[FLAG_POS] |=> ctl_rdata_o[FLAG_POS]); // R6
  AST_FLAG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ctl_we_i && !any_over && !ctl_rdata_o[FLAG_POS] |=> !ctl_rdata_o[FLAG_POS]); // R6
  AST_CTL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
    ctl_we_i |=> (ctl_rdata_o & ~FLAG_MASK) == $past(ctl_wdata_i & ~FLAG_MASK)); // R8
  AST_CTL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ctl_we_i |=> $stable(ctl_rdata_o & ~FLAG_MASK)); // R8
  AST_VALID_ON: assert property (@(posedge clk_i) disable iff (!rst_n)
    op_valid_i |=> res_valid_o); // R7
  AST_VALID_OFF: assert property (@(posedge clk_i) disable iff (!rst_n)
    !op_valid_i |=> !res_valid_o); // R7
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !op_valid_i |=> $stable(res_o)); // R7

endmodule

bind dqp_packer dqp_packer_chk #(
  .OP_W     (OP_W),
  .CTRL_W   (CTRL_W),
  .FLAG_POS (FLAG_POS)
) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .op_valid_i  (op_valid_i),
  .op_hi_i     (op_hi_i),
  .op_lo_i     (op_lo_i),
  .res_valid_o (res_valid_o),
  .res_o       (res_o),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i),
  .ctl_rdata_o (ctl_rdata_o)
);

// File: tb/dqp_packer_tb.sv
module dqp_packer_tb;

  localparam int unsigned FLAG = 22;

  logic clk;
  logic rst_n;

  // Full-width instance
  logic        v32;
  logic [31:0] a32, b32, wd32;
  logic        we32;
  logic        rv32;
  logic [31:0] r32, rd32;

  // Small instance (8-bit operands, 4-bit halves)
  logic        v8;
  logic [7:0]  a8, b8;
  logic        we8;
  logic [31:0] wd8;
  logic        rv8;
  logic [7:0]  r8;
  logic [31:0] rd8;

  int checks;
  int errors;
  bit done;
  logic [31:0] exp_ctl32;
  logic [31:0] exp_ctl8;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  dqp_packer u_dut (
    .clk_i (clk), .rst_ni (rst_n), .op_valid_i (v32), .op_hi_i (a32), .op_lo_i (b32),
    .res_valid_o (rv32), .res_o (r32), .ctl_we_i (we32), .ctl_wdata_i (wd32),
    .ctl_rdata_o (rd32)
  );

  dqp_packer #(.OP_W(8), .CTRL_W(32), .FLAG_POS(FLAG)) u_dut_small (
    .clk_i (clk), .rst_ni (rst_n), .op_valid_i (v8), .op_hi_i (a8), .op_lo_i (b8),
    .res_valid_o (rv8), .res_o (r8), .ctl_we_i (we8), .ctl_wdata_i (wd8),
    .ctl_rdata_o (rd8)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Arithmetic model: round toward +inf to half width, saturate positive overflow
  function automatic longint model(input longint op, input int w, output bit sat);
    int h = w / 2;
    longint rnd = longint'(1) << (h - 1);
    longint mx  = (longint'(1) << (w - 1)) - 1;
    sat = op > (mx - rnd);
    if (sat) return rnd - 1;
    return ((op + rnd) >>> h) & ((longint'(1) << h) - 1);
  endfunction

  task automatic op32(input logic [31:0] a, input logic [31:0] b, input logic we,
                      input logic [31:0] wd, input string req);
    bit sh, sl;
    longint eh, el;
    logic [31:0] er;
    @(negedge clk);
    v32 = 1'b1; a32 = a; b32 = b; we32 = we; wd32 = wd;
    @(negedge clk);
    v32 = 1'b0; we32 = 1'b0;
    eh = model(longint'($signed(a)), 32, sh);
    el = model(longint'($signed(b)), 32, sl);
    er = {eh[15:0], el[15:0]};
    if (we) exp_ctl32 = wd;
    if (sh || sl) exp_ctl32[FLAG] = 1'b1;
    chk(r32 == er && rv32, req, {31'd0, rv32, r32}, {32'd1, er});
    chk(rd32 == exp_ctl32, req, rd32, exp_ctl32);
  endtask

  task automatic op8(input logic [7:0] a, input logic [7:0] b);
    bit sh, sl;
    longint eh, el;
    logic [7:0] er;
    @(negedge clk);
    v8 = 1'b1; a8 = a; b8 = b;
    @(negedge clk);
    v8 = 1'b0;
    eh = model(longint'($signed(a)), 8, sh);
    el = model(longint'($signed(b)), 8, sl);
    er = {eh[3:0], el[3:0]};
    if (sh || sl) exp_ctl8[FLAG] = 1'b1;
    chk(r8 == er && rv8, "R1 R2 R3 small", {55'd0, rv8, r8}, {56'd1, er});
    chk(rd8 == exp_ctl8, "R4 R5 R6 small", rd8, exp_ctl8);
  endtask

  task automatic wr32(input logic [31:0] wd);
    @(negedge clk);
    we32 = 1'b1; wd32 = wd;
    @(negedge clk);
    we32 = 1'b0;
    exp_ctl32 = wd;
    chk(rd32 == wd, "R8 write readback", rd32, wd);
  endtask

  task automatic wr8(input logic [31:0] wd);
    @(negedge clk);
    we8 = 1'b1; wd8 = wd;
    @(negedge clk);
    we8 = 1'b0;
    exp_ctl8 = wd;
  endtask

  function automatic logic [31:0] pick32(input int i);
    logic [15:0] up, lw;
    case (i[7:4])
      4'd0: up = 16'h0000;  4'd1: up = 16'h0001;  4'd2: up = 16'h7FFE;  4'd3: up = 16'h7FFF;
      4'd4: up = 16'h8000;  4'd5: up = 16'h8001;  4'd6: up = 16'hFFFF;  4'd7: up = 16'hFFFE;
      4'd8: up = 16'h1234;  4'd9: up = 16'hBEEF;  4'd10: up = 16'h4000; 4'd11: up = 16'hC000;
      4'd12: up = 16'h7FF0; 4'd13: up = 16'h0FFF; 4'd14: up = 16'h8654; default: up = 16'h3FFF;
    endcase
    case (i[3:0])
      4'd0: lw = 16'h0000;  4'd1: lw = 16'h7FFE;  4'd2: lw = 16'h7FFF;  4'd3: lw = 16'h8000;
      4'd4: lw = 16'h8001;  4'd5: lw = 16'hFFFF;  4'd6: lw = 16'h0001;  4'd7: lw = 16'hC678;
      4'd8: lw = 16'h32A0;  4'd9: lw = 16'hFEED;  4'd10: lw = 16'h4000; 4'd11: lw = 16'hBFFF;
      4'd12: lw = 16'h7F00; 4'd13: lw = 16'h80FF; 4'd14: lw = 16'h1111; default: lw = 16'hEEEE;
    endcase
    return {up, lw};
  endfunction

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    exp_ctl32 = '0; exp_ctl8 = '0;
    v32 = 0; a32 = '0; b32 = '0; we32 = 0; wd32 = '0;
    v8 = 0; a8 = '0; b8 = '0; we8 = 0; wd8 = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    chk(r32 == 0 && !rv32, "R10 result after reset", {31'd0, rv32, r32}, 64'd0);
    chk(rd32 == 0, "R10 control after reset", rd32, 0);

    // Known vectors with the flag cleared first (R3 R4)
    wr32(32'h0);
    op32(32'h7FFFC678, 32'h865432A0, 1'b0, 0, "R3 R4 vector A");
    wr32(32'h0);
    op32(32'hBEEFFEED, 32'h7FFF8000, 1'b0, 0, "R2 R3 vector B");
    // Boundary: exactly at and just above the threshold
    wr32(32'h0);
    op32(32'h7FFF7FFF, 32'h80000000, 1'b0, 0, "R1 R5 threshold edge no sat");
    op32(32'h7FFF8000, 32'hFFFFFFFF, 1'b0, 0, "R3 R4 just above threshold");
    // R6: non-saturating op keeps flag set
    op32(32'h00018000, 32'hFFFF7FFF, 1'b0, 0, "R6 flag sticky");
    // R9: write and saturation in the same cycle
    op32(32'h7FFFFFFF, 32'h0, 1'b1, 32'h0000_1234, "R9 set wins over write");
    op32(32'h1, 32'h2, 1'b1, 32'hFFBF_FFFF, "R9 write clears flag");
    op32(32'h1, 32'h2, 1'b1, 32'h0040_0000, "R8 write sets flag");
    // R5: most negative operands leave flag clear
    wr32(32'hA5A5_A5A5 & ~(32'h1 << FLAG));
    op32(32'h80000000, 32'hFFFF8000, 1'b0, 0, "R5 negatives no flag");

    // R7: idle cycles hold the result and drop valid
    begin
      logic [31:0] held;
      held = r32;
      repeat (3) @(negedge clk);
      chk(!rv32 && r32 == held, "R7 hold when idle", {31'd0, rv32, r32}, {32'd0, held});
    end

    // Full-width boundary sweep (R1 R2 R3 R4 R6 R8)
    for (int i = 0; i < 256; i++) begin
      if (i % 5 == 0) wr32(32'h1357_9BDF ^ (i * 32'h0101_0101));
      op32(pick32(i), pick32((i * 7 + 3) & 255), 1'b0, 0, "R1 R2 R3 sweep");
    end

    // Small instance, near-exhaustive (R1 R2 R3 R4 R5 R6)
    wr8(32'h0);
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j += 17) begin
        if (((i + j) & 63) == 0) wr8(32'h0);
        op8(8'(i), 8'(j));
        op8(8'(j), 8'(i));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule